// File: doc/BRIEF.md
# Linked breakpoint match unit

This block decides, for every accepted instruction fetch, which of a set of breakpoint pairs fire. Each pair holds a 32-bit value and a small set of control fields. A two-bit mode field says what the value is compared with: the fetch address or the current context ID. It also says whether the pair is linked to another pair. An address pair can name a context pair as its link target. Such a pair fires only when its own address matches and the named context pair matches the context ID on the same fetch. Both pairs must be enabled.

Fetches arrive on a valid/ready stream together with the context ID and the monitor-mode flag. Each accepted fetch produces exactly one result on an output valid/ready stream, one cycle later. The result carries a per-pair hit vector and a single breakpoint-event bit. The output stage holds one result. While that result is valid and `res_ready` is low, `fetch_ready` is low. The result then stays unchanged until the consumer takes it. The configuration inputs are treated as quasi-static. They may change only while no fetch is being offered.

Top module: `bp_match_unit`

## Requirements
- R1: A pair in mode 00 (mode bit 1 = meaning, bit 0 = link) hits when it is enabled, its value bits 31:2 equal fetch address bits 31:2, the selected byte lane is allowed, and the privilege check passes.
- R2: Byte-select bit n allows a hit when the fetch lane is n. Select 0000 never hits, and 1111 hits on any byte of the word.
- R3: The lane is fetch address bits 1:0 for a little-endian fetch. It is those bits XOR 2'b10 for a big-endian fetch (`fetch_big_endian` = 1). So select 0011 hits at offset 00 little-endian and at offset 10 big-endian.
- R4: Privilege select 01 hits only when `fetch_priv` = 1, 10 only when `fetch_priv` = 0, 11 always, and 00 never.
- R5: A pair in mode 01 hits only when its own address, lane and privilege checks pass in the same fetch as the named target's context match. The target (the index in the 4-bit link field) must be in mode 11 and enabled. The target's privilege select is ignored.
- R6: A mode-01 pair never hits if its link names itself, names an index of 6 or more, names a pair below index 4, or names a pair not in mode 11.
- R7: Only pairs 4 and 5 can match a context ID. A context match needs the value to equal `ctx_id` and byte select 1111. Pairs 0 to 3 never hit in modes 10 or 11, and a mode-11 pair never raises its own hit.
- R8: A mode-10 pair hits on a context match with its privilege check passing. The hit is suppressed while `monitor_mode` = 1 and `fetch_priv` = 1. Linked hits are not suppressed.
- R9: Several mode-01 pairs may name the same context pair and hit together.
- R10: A pair whose enable bit is 0 never hits.
- R11: Each accepted fetch produces one result on the next clock with `res_valid` = 1, and `res_event` equals the OR of `res_hits`.
- R12: While `res_valid` = 1 and `res_ready` = 0, `fetch_ready` is 0 and `res_hits` stays unchanged.
- R13: In reset, `res_valid` and `res_hits` are 0 and `fetch_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch offered |
| fetch_ready | output | 1 | Fetch accepted when high together with valid |
| fetch_addr | input | 32 | Fetch virtual address |
| fetch_priv | input | 1 | 1 = privileged access, 0 = user access |
| fetch_big_endian | input | 1 | 1 = big-endian fetch |
| ctx_id | input | 32 | Current context ID |
| monitor_mode | input | 1 | Debug logic in monitor mode |
| cfg_value | input | NUM_PAIRS*32 | Per-pair compare value |
| cfg_mode | input | NUM_PAIRS*2 | Per-pair mode {meaning, link} |
| cfg_link | input | NUM_PAIRS*4 | Per-pair link target index |
| cfg_bsel | input | NUM_PAIRS*4 | Per-pair byte-lane select |
| cfg_priv | input | NUM_PAIRS*2 | Per-pair privilege select |
| cfg_en | input | NUM_PAIRS | Per-pair enable |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_hits | output | NUM_PAIRS | Per-pair hit vector |
| res_event | output | 1 | Breakpoint event (OR of hits) |

## Verification
A linked address hit and an unlinked context-only hit on pair 5 can fall in the same fetch. Monitor-mode suppression must then remove only the context-only bit. The bench provokes this by programming pair 5 in mode 10 while pair 1 links to pair 4. It issues privileged fetches with monitor mode both on and off. The scoreboard expects bit 1 alone in the first case and bits 1 and 5 in the second. A second collision comes from a link to pair 5 while pair 5 is in mode 10. There the link is rejected and pair 5 still fires on its own, so the expected vector holds bit 5 and not the linking pair.

// File: rtl/bp_match_pkg.sv
package bp_match_pkg;
  localparam int VAL_W  = 32;
  localparam int LINK_W = 4;
  localparam int BSEL_W = 4;

  typedef enum logic [1:0] {
    MODE_ADDR      = 2'b00,
    MODE_ADDR_LINK = 2'b01,
    MODE_CTX       = 2'b10,
    MODE_CTX_TGT   = 2'b11
  } bp_mode_e;

  typedef enum logic [1:0] {
    PRV_NONE = 2'b00,
    PRV_PRIV = 2'b01,
    PRV_USER = 2'b10,
    PRV_ANY  = 2'b11
  } bp_priv_e;
endpackage

// File: rtl/bp_pair_cmp.sv
module bp_pair_cmp
  import bp_match_pkg::*;
(
  input  logic [VAL_W-1:0]  value,
  input  logic [BSEL_W-1:0] bsel,
  input  logic [1:0]        priv_sel,
  input  logic              en,
  input  logic [VAL_W-1:0]  fetch_addr,
  input  logic              fetch_priv,
  input  logic              fetch_big_endian,
  input  logic [VAL_W-1:0]  ctx_id,
  output logic              addr_hit,
  output logic              ctx_hit,
  output logic              priv_ok
);
  logic [1:0] lane;
  logic       word_eq;

  // big-endian fetch swaps halfwords inside the word
  assign lane    = fetch_addr[1:0] ^ {fetch_big_endian, 1'b0};
  assign word_eq = (value[VAL_W-1:2] == fetch_addr[VAL_W-1:2]);

  always_comb begin
    unique case (bp_priv_e'(priv_sel))
      PRV_PRIV: priv_ok = fetch_priv;
      PRV_USER: priv_ok = !fetch_priv;
      PRV_ANY:  priv_ok = 1'b1;
      default:  priv_ok = 1'b0;
    endcase
  end

  assign addr_hit = en && word_eq && bsel[lane] && priv_ok;
  // context compare uses every lane; capability is decided by the resolver
  assign ctx_hit  = (value == ctx_id) && (&bsel);
endmodule

// File: rtl/bp_link_resolve.sv
module bp_link_resolve
  import bp_match_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int CTX_FIRST = 4
) (
  input  logic [NUM_PAIRS-1:0][1:0]        mode,
  input  logic [NUM_PAIRS-1:0][LINK_W-1:0] link,
  input  logic [NUM_PAIRS-1:0]             en,
  input  logic [NUM_PAIRS-1:0]             addr_hit,
  input  logic [NUM_PAIRS-1:0]             ctx_hit,
  input  logic [NUM_PAIRS-1:0]             priv_ok,
  input  logic                             monitor_mode,
  input  logic                             fetch_priv,
  output logic [NUM_PAIRS-1:0]             hits
);
  logic suppress_ctx;
  assign suppress_ctx = monitor_mode && fetch_priv;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    localparam bit CAPABLE = (i >= CTX_FIRST);
    logic tgt_ok;
    logic hit_i;

    always_comb begin
      tgt_ok = 1'b0;
      for (int t = CTX_FIRST; t < NUM_PAIRS; t++) begin
        if ((t != i) && (link[i] == LINK_W'(t)) &&
            (bp_mode_e'(mode[t]) == MODE_CTX_TGT) && en[t] && ctx_hit[t])
          tgt_ok = 1'b1;
      end
    end

    always_comb begin
      unique case (bp_mode_e'(mode[i]))
        MODE_ADDR:      hit_i = addr_hit[i];
        MODE_ADDR_LINK: hit_i = addr_hit[i] && tgt_ok;
        MODE_CTX:       hit_i = CAPABLE && en[i] && ctx_hit[i] &&
                                priv_ok[i] && !suppress_ctx;
        default:        hit_i = 1'b0;
      endcase
    end

    assign hits[i] = hit_i;
  end
endmodule

// File: rtl/bp_result_stage.sv
module bp_result_stage #(
  parameter int NUM_PAIRS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_PAIRS-1:0] hits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PAIRS-1:0] out_hits,
  output logic                 out_event
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hits  <= '0;
      out_event <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hits  <= hits;
        out_event <= |hits;
      end
    end
  end
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
  import bp_match_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int CTX_FIRST = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_valid,
  output logic                        fetch_ready,
  input  logic [VAL_W-1:0]            fetch_addr,
  input  logic                        fetch_priv,
  input  logic                        fetch_big_endian,
  input  logic [VAL_W-1:0]            ctx_id,
  input  logic                        monitor_mode,
  input  logic [NUM_PAIRS*VAL_W-1:0]  cfg_value,
  input  logic [NUM_PAIRS*2-1:0]      cfg_mode,
  input  logic [NUM_PAIRS*LINK_W-1:0] cfg_link,
  input  logic [NUM_PAIRS*BSEL_W-1:0] cfg_bsel,
  input  logic [NUM_PAIRS*2-1:0]      cfg_priv,
  input  logic [NUM_PAIRS-1:0]        cfg_en,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic [NUM_PAIRS-1:0]        res_hits,
  output logic                        res_event
);
  logic [NUM_PAIRS-1:0][1:0]        mode_a;
  logic [NUM_PAIRS-1:0][LINK_W-1:0] link_a;
  logic [NUM_PAIRS-1:0]             addr_hit;
  logic [NUM_PAIRS-1:0]             ctx_hit;
  logic [NUM_PAIRS-1:0]             priv_ok;
  logic [NUM_PAIRS-1:0]             hits;

  assign mode_a = cfg_mode;
  assign link_a = cfg_link;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_cmp
    bp_pair_cmp u_cmp (
      .value            (cfg_value[i*VAL_W +: VAL_W]),
      .bsel             (cfg_bsel[i*BSEL_W +: BSEL_W]),
      .priv_sel         (cfg_priv[i*2 +: 2]),
      .en               (cfg_en[i]),
      .fetch_addr       (fetch_addr),
      .fetch_priv       (fetch_priv),
      .fetch_big_endian (fetch_big_endian),
      .ctx_id           (ctx_id),
      .addr_hit         (addr_hit[i]),
      .ctx_hit          (ctx_hit[i]),
      .priv_ok          (priv_ok[i])
    );
  end

  bp_link_resolve #(
    .NUM_PAIRS (NUM_PAIRS),
    .CTX_FIRST (CTX_FIRST)
  ) u_resolve (
    .mode         (mode_a),
    .link         (link_a),
    .en           (cfg_en),
    .addr_hit     (addr_hit),
    .ctx_hit      (ctx_hit),
    .priv_ok      (priv_ok),
    .monitor_mode (monitor_mode),
    .fetch_priv   (fetch_priv),
    .hits         (hits)
  );

  bp_result_stage #(
    .NUM_PAIRS (NUM_PAIRS)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fetch_valid),
    .in_ready  (fetch_ready),
    .hits      (hits),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_hits  (res_hits),
    .out_event (res_event)
  );
endmodule

// File: rtl/bp_match_unit_chk.sv
module bp_match_unit_chk #(
  parameter int NUM_PAIRS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fetch_valid,
  input logic                   fetch_ready,
  input logic [NUM_PAIRS*2-1:0] cfg_mode,
  input logic [NUM_PAIRS-1:0]   cfg_en,
  input logic                   res_valid,
  input logic                   res_ready,
  input logic [NUM_PAIRS-1:0]   res_hits,
  input logic                   res_event
);
  logic [NUM_PAIRS-1:0] tgt_mask;
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_mask
    assign tgt_mask[i] = (cfg_mode[i*2 +: 2] == 2'b11);
  end

  // R13
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !res_valid);

  // R12
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !fetch_ready);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hits));

  // R11
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> res_valid);

  // R11
  event_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_event == (res_hits != '0)));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> (res_hits & ~$past(cfg_en)) == '0);

  // R7
  target_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> (res_hits & $past(tgt_mask)) == '0);
endmodule

bind bp_match_unit bp_match_unit_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .cfg_mode    (cfg_mode),
  .cfg_en      (cfg_en),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_hits    (res_hits),
  .res_event   (res_event)
);

// File: tb/bp_match_unit_test.sv
module bp_match_unit_test;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              fetch_valid = 1'b0;
  logic              fetch_ready;
  logic [31:0]       fetch_addr = '0;
  logic              fetch_priv = 1'b0;
  logic              fetch_big_endian = 1'b0;
  logic [31:0]       ctx_id = '0;
  logic              monitor_mode = 1'b0;
  logic [NP*32-1:0]  cfg_value;
  logic [NP*2-1:0]   cfg_mode;
  logic [NP*4-1:0]   cfg_link;
  logic [NP*4-1:0]   cfg_bsel;
  logic [NP*2-1:0]   cfg_priv;
  logic [NP-1:0]     cfg_en;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [NP-1:0]     res_hits;
  logic              res_event;

  logic [31:0] c_val  [NP];
  logic [1:0]  c_mode [NP];
  logic [3:0]  c_link [NP];
  logic [3:0]  c_bsel [NP];
  logic [1:0]  c_priv [NP];
  logic        c_en   [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      cfg_value[i*32 +: 32] = c_val[i];
      cfg_mode[i*2 +: 2]    = c_mode[i];
      cfg_link[i*4 +: 4]    = c_link[i];
      cfg_bsel[i*4 +: 4]    = c_bsel[i];
      cfg_priv[i*2 +: 2]    = c_priv[i];
      cfg_en[i]             = c_en[i];
    end
  end

  bp_match_unit #(.NUM_PAIRS(NP), .CTX_FIRST(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_priv(fetch_priv),
    .fetch_big_endian(fetch_big_endian), .ctx_id(ctx_id),
    .monitor_mode(monitor_mode),
    .cfg_value(cfg_value), .cfg_mode(cfg_mode), .cfg_link(cfg_link),
    .cfg_bsel(cfg_bsel), .cfg_priv(cfg_priv), .cfg_en(cfg_en),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_hits(res_hits), .res_event(res_event)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [NP-1:0] exp_hits [$];
  string         exp_tag  [$];
  int rr_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input string req, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference built from the requirement text
  function automatic logic [NP-1:0] model_hits(input logic [31:0] a,
      input logic p, input logic be);
    logic [NP-1:0] h;
    h = '0;
    for (int i = 0; i < NP; i++) begin
      int  lane;
      int  t;
      bit  prv_ok, word, lane_ok, tgt;
      lane    = be ? int'(a[1:0] ^ 2'b10) : int'(a[1:0]);
      prv_ok  = (c_priv[i] == 2'b11) || (c_priv[i] == 2'b01 && p) ||
                (c_priv[i] == 2'b10 && !p);
      word    = (c_val[i][31:2] == a[31:2]);
      lane_ok = c_bsel[i][lane];
      t       = int'(c_link[i]);
      tgt     = 1'b0;
      if (t != i && t >= 4 && t < NP)
        tgt = (c_mode[t] == 2'b11) && c_en[t] && (c_val[t] == ctx_id) &&
              (c_bsel[t] == 4'hF);
      if (c_en[i]) begin
        case (c_mode[i])
          2'b00: h[i] = word && lane_ok && prv_ok;
          2'b01: h[i] = word && lane_ok && prv_ok && tgt;
          2'b10: h[i] = (i >= 4) && (c_val[i] == ctx_id) && (c_bsel[i] == 4'hF) &&
                        prv_ok && !(monitor_mode && p);
          default: h[i] = 1'b0;
        endcase
      end
    end
    return h;
  endfunction

  task automatic clear_cfg();
    for (int i = 0; i < NP; i++) begin
      c_val[i] = '0; c_mode[i] = 2'b00; c_link[i] = '0;
      c_bsel[i] = 4'hF; c_priv[i] = 2'b11; c_en[i] = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] a, input logic p, input logic be,
                      input string tag);
    logic acc;
    @(negedge clk);
    fetch_addr = a; fetch_priv = p; fetch_big_endian = be; fetch_valid = 1'b1;
    while (1) begin
      #1 acc = fetch_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    exp_hits.push_back(model_hits(a, p, be));
    exp_tag.push_back(tag);
    #1 fetch_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_hits.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    res_ready <= (rr_mode == 0) ? 1'b1 : (rr_mode == 1) ? lfsr[0] : 1'b0;
  end

  // monitor: compares each result the consumer takes
  always @(negedge clk) begin
    #2;
    if (rst_n && res_valid && res_ready) begin
      if (exp_hits.size() == 0) begin
        check("R11", 1'b0, 32'(res_hits), 32'h0);
      end else begin
        logic [NP-1:0] eh;
        string tg;
        eh = exp_hits.pop_front();
        tg = exp_tag.pop_front();
        check(tg, res_hits == eh, 32'(res_hits), 32'(eh));
        check("R11", res_event == (|eh), 32'(res_event), 32'(|eh));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1'b0, 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    #1;
    check("R13", !res_valid, 32'(res_valid), 32'h0);
    check("R13", res_hits == '0, 32'(res_hits), 32'h0);
    check("R13", fetch_ready, 32'(fetch_ready), 32'h1);
    rst_n = 1'b1;

    // R1: plain address pair
    c_val[0] = 32'h1000; c_en[0] = 1'b1;
    send(32'h1000, 1, 0, "R1");
    send(32'h1004, 1, 0, "R1");
    send(32'h1003, 0, 0, "R1");
    send(32'h0FFC, 0, 0, "R1");
    // R2: byte lanes
    c_bsel[0] = 4'b0010;
    send(32'h1001, 1, 0, "R2");
    send(32'h1000, 1, 0, "R2");
    c_bsel[0] = 4'b0000;
    for (int k = 0; k < 4; k++) send(32'h1000 + 32'(k), 1, 0, "R2");
    // R3: big-endian lane adjust
    c_bsel[0] = 4'b0011;
    send(32'h1002, 1, 1, "R3");
    send(32'h1000, 1, 1, "R3");
    send(32'h1000, 1, 0, "R3");
    send(32'h1002, 1, 0, "R3");
    // R4: privilege select
    c_bsel[0] = 4'hF;
    for (int s = 0; s < 4; s++) begin
      c_priv[0] = 2'(s);
      send(32'h1000, 0, 0, "R4");
      send(32'h1000, 1, 0, "R4");
    end
    drain();

    // R5: linked address + context
    clear_cfg();
    c_val[4] = 32'h55; c_mode[4] = 2'b11; c_en[4] = 1'b1;
    c_val[1] = 32'h2000; c_mode[1] = 2'b01; c_link[1] = 4'd4;
    c_priv[1] = 2'b01; c_en[1] = 1'b1;
    ctx_id = 32'h55;
    send(32'h2000, 1, 0, "R5");
    send(32'h2000, 0, 0, "R5");
    ctx_id = 32'h56;
    send(32'h2000, 1, 0, "R5");
    ctx_id = 32'h55;
    c_priv[4] = 2'b10;
    send(32'h2000, 1, 0, "R5");
    c_en[4] = 1'b0;
    send(32'h2000, 1, 0, "R5");
    c_en[4] = 1'b1;
    c_bsel[4] = 4'b0111;
    send(32'h2000, 1, 0, "R7");
    c_bsel[4] = 4'hF;
    // R9: shared context target
    c_val[2] = 32'h2000; c_mode[2] = 2'b01; c_link[2] = 4'd4; c_en[2] = 1'b1;
    c_val[3] = 32'h3000; c_mode[3] = 2'b01; c_link[3] = 4'd4; c_en[3] = 1'b1;
    send(32'h2000, 1, 0, "R9");
    send(32'h3000, 1, 0, "R9");
    drain();

    // R6: bad links
    clear_cfg();
    c_val[4] = 32'h55; c_mode[4] = 2'b11; c_en[4] = 1'b1;
    c_val[1] = 32'h2000; c_mode[1] = 2'b01; c_en[1] = 1'b1;
    c_link[1] = 4'd1;  send(32'h2000, 1, 0, "R6");
    c_link[1] = 4'd7;  send(32'h2000, 1, 0, "R6");
    c_val[0] = 32'h55; c_mode[0] = 2'b11; c_en[0] = 1'b1;
    c_link[1] = 4'd0;  send(32'h2000, 1, 0, "R6");
    c_val[5] = 32'h55; c_mode[5] = 2'b10; c_en[5] = 1'b1;
    c_link[1] = 4'd5;  send(32'h2000, 1, 0, "R6");
    drain();

    // R7: context-only pairs
    clear_cfg();
    ctx_id = 32'h77;
    c_val[5] = 32'h77; c_mode[5] = 2'b10; c_en[5] = 1'b1;
    send(32'h4000, 0, 0, "R7");
    c_bsel[5] = 4'b0111;
    send(32'h4000, 0, 0, "R7");
    c_bsel[5] = 4'hF;
    c_val[3] = 32'h77; c_mode[3] = 2'b10; c_en[3] = 1'b1;
    c_val[4] = 32'h77; c_mode[4] = 2'b11; c_en[4] = 1'b1;
    send(32'h4000, 0, 0, "R7");
    // R8: monitor suppression beside a linked hit
    c_mode[3] = 2'b00; c_en[3] = 1'b0;
    c_val[1] = 32'h2000; c_mode[1] = 2'b01; c_link[1] = 4'd4; c_en[1] = 1'b1;
    monitor_mode = 1'b1;
    send(32'h2000, 1, 0, "R8");
    send(32'h2000, 0, 0, "R8");
    monitor_mode = 1'b0;
    send(32'h2000, 1, 0, "R8");
    // R10: disabled pairs
    c_en[1] = 1'b0; c_en[5] = 1'b0;
    c_val[0] = 32'h2000; c_mode[0] = 2'b00;
    send(32'h2000, 1, 0, "R10");
    drain();

    // R12: random back-pressure over mixed fetches
    c_en[0] = 1'b1; c_en[1] = 1'b1; c_en[5] = 1'b1;
    rr_mode = 1;
    for (int k = 0; k < 40; k++)
      send(32'h2000 + 32'(k % 5), k[0], k[1], "R12");
    drain();
    rr_mode = 2;
    repeat (2) @(negedge clk);
    send(32'h2000, 1, 0, "R12");
    @(negedge clk); #3;
    check("R12", res_valid && !fetch_ready, 32'(fetch_ready), 32'h0);
    begin
      logic [NP-1:0] held;
      held = res_hits;
      repeat (3) @(negedge clk);
      #3;
      check("R12", res_hits == held && res_valid, 32'(res_hits), 32'(held));
    end
    rr_mode = 0;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule